// File: doc/BRIEF.md
# Function Input Priority Router

This block feeds one peripheral function's input wire from a set of candidate I/O pins. Each pin carries a 2-bit mux code. The pin offers this function when its code equals the slot number the function holds on that pin. Every pin whose code matches raises a selector. The lowest-indexed raised selector wins, and that pin's sensed level is passed to the function. The levels of the other pins are never merged into the result. Merging them would let one pin driven high and another driven low fight over the same input.

When no pin selects the function, the output rests at a parameterised idle level. The default is high, so an idle serial receive line or an open-drain data line reads as released. A pin's level may go to several routers at once, because one pin may legally feed several function inputs. The resolution path is combinational. An optional output register adds one cycle of delay. With a single candidate pin and an idle level of 0, the block collapses to a two-input AND of selector and level. Functions that have no input direction get no instance of this block.

Top module: `fn_in_router`

## Requirements
- R1: Selector i is raised exactly when bits [2i+1:2i] of `pin_code` equal the 2-bit slot number held for pin i in bits [2i+1:2i] of the `SLOT_MAP` parameter. Any other code value leaves pin i out of contention.
- R2: When at least one selector is raised, the output equals `pin_lvl[k]`, where k is the lowest index with a raised selector.
- R3: The levels of pins other than the winning pin have no effect on the output. This holds whether those pins are selected or not.
- R4: When no selector is raised, the output equals `IDLE_LVL` whatever the pin levels are. The default value of `IDLE_LVL` is 1.
- R5: With `N_PINS` = 1 and `IDLE_LVL` = 0, the output is the AND of the single selector and `pin_lvl[0]`.
- R6: With `REG_OUT` = 1, the output shows at each rising clock edge the value the combinational path held just before that edge. With `REG_OUT` = 0, the output follows the inputs with no clock delay.
- R7: With `REG_OUT` = 1, the output reads `IDLE_LVL` while `rst_n` is low, regardless of the pin inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_code | input | 2*N_PINS | Per-pin 2-bit mux codes; pin i uses bits [2i+1:2i] |
| pin_lvl | input | N_PINS | Sensed pad level of each candidate pin |
| fn_in | output | 1 | Level delivered to the function input |

## Verification
The bench goes through every pattern of matching selectors over eight pins. Each pin that does not match is given one of the three codes that differ from its slot, so a decoder that matched too loosely, for example by comparing only one code bit, would raise false selectors and route the wrong pin. For each pattern, the level patterns set the winner against all the other pins. A resolver that picked the highest index, or that OR-merged the selected levels, would therefore output the losers' value. The empty pattern is checked with pins driven both high and low, so a design that leaked a pin level into the idle case would show it. The registered copy is checked one edge late and during reset. The single-pin AND form is checked on all four codes.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  localparam int MAX_PINS = 32;
  localparam int CODE_W   = 2;
  localparam int MAP_W    = MAX_PINS * CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MAP_W-1:0]  slot_map_t;

  // Default slot layout: pin i holds this function in slot (i mod 4).
  function automatic slot_map_t stripe_slots();
    slot_map_t r;
    r = '0;
    for (int i = 0; i < MAX_PINS; i++) begin
      r[i*CODE_W +: CODE_W] = code_t'(i % (1 << CODE_W));
    end
    return r;
  endfunction

  // Slot number held for one pin inside a packed slot map.
  function automatic code_t slot_of(input slot_map_t map, input int idx);
    return map[idx*CODE_W +: CODE_W];
  endfunction
endpackage

// File: rtl/fnr_sel_decode.sv
module fnr_sel_decode #(
  parameter int                  N_PINS   = 8,
  parameter fnr_pkg::slot_map_t  SLOT_MAP = fnr_pkg::stripe_slots()
) (
  input  logic [N_PINS*fnr_pkg::CODE_W-1:0] pin_code,
  output logic [N_PINS-1:0]                 sel
);
  localparam int CW = fnr_pkg::CODE_W;

  // One equality comparator per pin against its fixed slot number.
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    localparam fnr_pkg::code_t SLOT = fnr_pkg::slot_of(SLOT_MAP, g);
    assign sel[g] = (pin_code[g*CW +: CW] == SLOT);
  end
endmodule

// File: rtl/fnr_prio_pick.sv
module fnr_prio_pick #(
  parameter int N_PINS   = 8,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic [N_PINS-1:0] sel,
  input  logic [N_PINS-1:0] lvl,
  output logic [N_PINS-1:0] win,
  output logic              any_sel,
  output logic              data
);
  if (N_PINS == 1) begin : g_single
    // Only one path: the router is a single gate.
    assign win     = sel;
    assign any_sel = sel[0];
    if (IDLE_LVL) begin : g_idle_hi
      assign data = ~sel[0] | lvl[0];
    end else begin : g_idle_lo
      assign data = sel[0] & lvl[0];
    end
  end else begin : g_multi
    // Isolate the lowest raised selector, then gate levels by it.
    assign win     = sel & (~sel + 1'b1);
    assign any_sel = |sel;
    assign data    = any_sel ? |(win & lvl) : IDLE_LVL;
  end
endmodule

// File: rtl/fn_in_router.sv
module fn_in_router #(
  parameter int                 N_PINS   = 8,
  parameter fnr_pkg::slot_map_t SLOT_MAP = fnr_pkg::stripe_slots(),
  parameter bit                 IDLE_LVL = 1'b1,
  parameter bit                 REG_OUT  = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_PINS*fnr_pkg::CODE_W-1:0] pin_code,
  input  logic [N_PINS-1:0]                 pin_lvl,
  output logic                              fn_in
);
  logic [N_PINS-1:0] sel;
  logic [N_PINS-1:0] win;
  logic              any_sel;
  logic              comb_lvl;
  logic              armed_q;

  fnr_sel_decode #(
    .N_PINS  (N_PINS),
    .SLOT_MAP(SLOT_MAP)
  ) u_decode (
    .pin_code(pin_code),
    .sel     (sel)
  );

  fnr_prio_pick #(
    .N_PINS  (N_PINS),
    .IDLE_LVL(IDLE_LVL)
  ) u_pick (
    .sel    (sel),
    .lvl    (pin_lvl),
    .win    (win),
    .any_sel(any_sel),
    .data   (comb_lvl)
  );

  // Marks cycles whose previous edge was already out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  if (REG_OUT) begin : g_reg
    logic fn_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fn_q <= IDLE_LVL;
      else        fn_q <= comb_lvl;
    end
    assign fn_in = fn_q;

    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> fn_in == $past(comb_lvl)); // R6
  end else begin : g_comb
    assign fn_in = comb_lvl;
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R2
  AST_WIN_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (win & ~sel) == '0); // R1
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> (((win - 1'b1) & sel) == '0 && win != '0)); // R2
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !any_sel |-> comb_lvl == IDLE_LVL); // R4
endmodule

// File: tb/fn_in_router_tb.sv
module fn_in_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_code = '0;
  logic [7:0]  pin_lvl = '0;
  logic [1:0]  one_code = '0;
  logic [0:0]  one_lvl = '0;
  logic        y_comb, y_reg, y_one;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fn_in_router #(.N_PINS(8), .SLOT_MAP(64'h0000_0000_0000_E4E4),
                 .IDLE_LVL(1'b1), .REG_OUT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .pin_lvl(pin_lvl), .fn_in(y_comb));

  fn_in_router #(.N_PINS(8), .SLOT_MAP(64'h0000_0000_0000_E4E4),
                 .IDLE_LVL(1'b1), .REG_OUT(1'b1)) u_dut_reg (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .pin_lvl(pin_lvl), .fn_in(y_reg));

  fn_in_router #(.N_PINS(1), .SLOT_MAP(64'h2),
                 .IDLE_LVL(1'b0), .REG_OUT(1'b0)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .pin_code(one_code), .pin_lvl(one_lvl), .fn_in(y_one));

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (code=%h lvl=%h)", tag, got, exp, pin_code, pin_lvl);
    end
  endtask

  // Slot of pin i is i mod 4 (matches the map 16'hE4E4).
  function automatic logic [15:0] make_codes(input int m);
    logic [15:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      s = 2'(i % 4);
      c[i*2 +: 2] = m[i] ? s : (s ^ 2'(1 + ((m + i) % 3)));
    end
    return c;
  endfunction

  function automatic int lowest(input int m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    // Reset state: pin 0 selected, driven low; registered output must be idle.
    pin_code = make_codes(1);
    pin_lvl  = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset idle", y_reg, 1'b1);
    check("R2 comb during reset", y_comb, 1'b0);
    rst_n = 1'b1;

    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 4; p++) begin
        int  w;
        logic exp;
        string tag;
        w = lowest(m);
        case (p)
          0: pin_lvl = 8'h00;
          1: pin_lvl = 8'hFF;
          2: pin_lvl = (w < 0) ? 8'h5A : (8'h01 << w);
          default: pin_lvl = (w < 0) ? 8'hA5 : ~(8'h01 << w);
        endcase
        @(negedge clk);
        pin_code = make_codes(m);
        if (w < 0) begin
          exp = 1'b1;
          tag = "R4 idle";
        end else begin
          exp = pin_lvl[w];
          tag = (p < 2) ? "R2 lowest wins" : "R3 losers ignored";
        end
        #1;
        check(tag, y_comb, exp);
        if (p == 0 && w >= 0) check("R1 decode", y_comb, 1'b0);
        @(posedge clk);
        #1;
        check("R6 registered", y_reg, exp);
      end
    end

    // Single-pin AND form, slot 2.
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 2; l++) begin
        @(negedge clk);
        one_code = 2'(c);
        one_lvl  = 1'(l);
        #1;
        check("R5 single pin", y_one, (c == 2) && (l == 1));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule